// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Wildcards

This block watches the once-per-second update of a real-time clock. On every accepted update strobe it compares the freshly updated seconds, minutes and hours bytes with three alarm bytes. One cycle later it drives an update-finished pulse and, when every alarm field agrees with the time, an alarm pulse in that same cycle. The time counter and the register file that hold these bytes sit outside the block. The block only reads their values.

The bytes are packed BCD by default, with the tens digit in the upper nibble. When the binary-mode input is high they are plain binary. Hour bytes may use a 12-hour encoding with a PM marker in bit 7. Both the current hour and the alarm hour are brought to a common 0 to 23 value before they are compared. An alarm byte with bits 7:6 both set is a wildcard and matches any value of its field. Three wildcards therefore give an alarm on every update. While the dividers are held in reset the clock does not advance, so strobes are ignored.

Top module: `tod_alarm_cmp`

## Requirements
- R1: While reset (rst_n low) is sampled at a clock edge, both upd_done and alarm_hit are 0 after that edge.
- R2: An upd_stb cycle with div_hold low produces upd_done high for exactly the following cycle. With no strobe, upd_done stays low.
- R3: An upd_stb cycle with div_hold high is ignored: neither upd_done nor alarm_hit rises in the following cycle.
- R4: In BCD mode (bin_mode = 0) and 24-hour mode (h24_mode = 1), alarm_hit rises together with upd_done when all three alarm bytes equal the current bytes.
- R5: A difference in any single non-wildcard field keeps alarm_hit low, while upd_done still pulses.
- R6: An alarm byte whose bits 7:6 are 2'b11 matches any current value of its field. The other fields are still compared.
- R7: When all three alarm bytes are wildcards, alarm_hit pulses on every accepted update, whatever the time.
- R8: With bin_mode = 1 the bytes are compared as binary values (for example 0x1E means 30). With bin_mode = 0 they are decoded as tens*10 + units, with tens in bits 7:4 and units in bits 3:0.
- R9: With h24_mode = 0, hour bit 7 marks PM. The decoded hour 12 becomes 0, and PM adds 12. Current and alarm hours match when these 0 to 23 values are equal (0x12 equals 0x00, and 0x81 differs from 0x01).
- R10: alarm_hit is never high in a cycle where upd_done is low.
- R11: With h24_mode = 1, hour bit 7 is dropped before decoding (alarm hour 0x95 matches current hour 0x15).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_stb | input | 1 | One-cycle strobe: the time bytes now hold the updated time |
| div_hold | input | 1 | Dividers held in reset; update strobes are ignored |
| bin_mode | input | 1 | 1 = binary bytes, 0 = packed BCD |
| h24_mode | input | 1 | 1 = 24-hour hours, 0 = 12-hour hours with PM in bit 7 |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| upd_done | output | 1 | One-cycle pulse: an update was accepted |
| alarm_hit | output | 1 | One-cycle pulse: the accepted update matched the alarm |

## Verification
The only state is the flag register, so any error in it shows at the ports in the cycle right after a strobe. Possible faults are a lost or stretched pulse, a pulse during divider hold, or an alarm pulse without an update pulse. Faults in the decode path produce no stored state and show only as a wrong alarm_hit in that same cycle. Such a fault appears only when the data makes the two encodings differ, so the tests pair BCD with binary readings of the same byte, noon and midnight in 12-hour form, and a stray PM bit in 24-hour form.

// File: rtl/tod_alarm_pkg.sv
// Package: shared constants for the time-of-day alarm comparator.
// Assumes byte-wide time fields and three fields (seconds, minutes, hours).
package tod_alarm_pkg;
    localparam int TOD_BYTE_W    = 8;
    localparam int TOD_NUM_FLD   = 3;
    localparam int TOD_HOUR_IDX  = 2;
    localparam logic [1:0] TOD_WILD_TAG = 2'b11;
    localparam int TOD_HALF_DAY  = 12;

    typedef enum logic [1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2
    } tod_fld_e;
endpackage

// File: rtl/tod_byte_decode.sv
// Module: tod_byte_decode
// Turns one raw time byte into a plain numeric value. With IS_HOUR set,
// bit 7 is treated as the PM marker: it is stripped before decoding and,
// in 12-hour mode, the value is folded to 0..23 (12 -> 0, PM adds 12).
// Assumes: purely combinational; malformed BCD digits decode arithmetically.
module tod_byte_decode
    import tod_alarm_pkg::*;
#(
    parameter int BYTE_W  = TOD_BYTE_W,
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [BYTE_W-1:0] raw,
    input  logic              bin_mode,
    input  logic              h24_mode,
    output logic [BYTE_W-1:0] val
);
    localparam int NIB_W = BYTE_W / 2;
    localparam logic [BYTE_W-1:0] HALF_DAY = BYTE_W'(TOD_HALF_DAY);

    logic [BYTE_W-1:0] body;
    logic [BYTE_W-1:0] tens;
    logic [BYTE_W-1:0] units;
    logic [BYTE_W-1:0] plain;
    logic              pm_flag;

    // Strip the PM marker from hour bytes; other fields pass unchanged.
    generate
        if (IS_HOUR) begin : g_hour_body
            assign body    = {1'b0, raw[BYTE_W-2:0]};
            assign pm_flag = raw[BYTE_W-1];
        end else begin : g_plain_body
            assign body    = raw;
            assign pm_flag = 1'b0;
        end
    endgenerate

    // Packed-BCD to binary: tens*10 built from shifts, plus units.
    always_comb begin
        tens  = BYTE_W'(body[BYTE_W-1:NIB_W]);
        units = BYTE_W'(body[NIB_W-1:0]);
        if (bin_mode) begin
            plain = body;
        end else begin
            plain = (tens << 3) + (tens << 1) + units;
        end
    end

    // Fold the 12-hour form onto the 0..23 scale for hour fields.
    generate
        if (IS_HOUR) begin : g_hour_fold
            always_comb begin
                if (h24_mode) begin
                    val = plain;
                end else begin
                    val = (plain % HALF_DAY) + (pm_flag ? HALF_DAY : '0);
                end
            end
        end else begin : g_no_fold
            logic unused_h24;
            assign unused_h24 = h24_mode;
            assign val = plain;
        end
    endgenerate
endmodule

// File: rtl/tod_field_match.sv
// Module: tod_field_match
// Compares one current time byte with its alarm byte. The alarm byte is a
// wildcard when its top two bits equal the wildcard tag; otherwise both
// bytes are decoded the same way and compared as numbers.
// Assumes: combinational; both bytes share the same encoding modes.
module tod_field_match
    import tod_alarm_pkg::*;
#(
    parameter int BYTE_W  = TOD_BYTE_W,
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [BYTE_W-1:0] cur_raw,
    input  logic [BYTE_W-1:0] alm_raw,
    input  logic              bin_mode,
    input  logic              h24_mode,
    output logic              hit
);
    logic [BYTE_W-1:0] cur_val;
    logic [BYTE_W-1:0] alm_val;
    logic              wild;

    tod_byte_decode #(.BYTE_W(BYTE_W), .IS_HOUR(IS_HOUR)) i_dec_cur (
        .raw      (cur_raw),
        .bin_mode (bin_mode),
        .h24_mode (h24_mode),
        .val      (cur_val)
    );

    tod_byte_decode #(.BYTE_W(BYTE_W), .IS_HOUR(IS_HOUR)) i_dec_alm (
        .raw      (alm_raw),
        .bin_mode (bin_mode),
        .h24_mode (h24_mode),
        .val      (alm_val)
    );

    // Wildcard detection works on the raw alarm byte, before any decoding.
    assign wild = (alm_raw[BYTE_W-1:BYTE_W-2] == TOD_WILD_TAG);

    // A field matches when it is a wildcard or the decoded values agree.
    assign hit = wild || (cur_val == alm_val);
endmodule

// File: rtl/tod_flag_stage.sv
// Module: tod_flag_stage
// Registers the update-finished and alarm pulses one cycle after an
// accepted strobe. Assumes the accept input is at most one cycle per update.
module tod_flag_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic all_match,
    output logic upd_done,
    output logic alarm_hit
);
    // Capture pulses on accepted strobes; clear otherwise or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_done  <= 1'b0;
            alarm_hit <= 1'b0;
        end else begin
            upd_done  <= accept;
            alarm_hit <= accept && all_match;
        end
    end
endmodule

// File: rtl/tod_alarm_cmp.sv
// Module: tod_alarm_cmp (top)
// At each accepted once-per-second strobe, compares seconds, minutes and
// hours against three alarm bytes and pulses upd_done, plus alarm_hit
// when every field matches. Strobes seen while the dividers are held are
// dropped. Assumes the time bytes are stable in the strobe cycle.
module tod_alarm_cmp
    import tod_alarm_pkg::*;
#(
    parameter int BYTE_W = TOD_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_stb,
    input  logic              div_hold,
    input  logic              bin_mode,
    input  logic              h24_mode,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_hour,
    input  logic [BYTE_W-1:0] alm_sec,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_hour,
    output logic              upd_done,
    output logic              alarm_hit
);
    localparam int NFLD = TOD_NUM_FLD;

    logic [BYTE_W-1:0] cur_arr [NFLD];
    logic [BYTE_W-1:0] alm_arr [NFLD];
    logic [NFLD-1:0]   fld_hit;
    logic              accept;

    // Gather the fields into arrays indexed by field number.
    assign cur_arr[FLD_SEC]  = cur_sec;
    assign cur_arr[FLD_MIN]  = cur_min;
    assign cur_arr[FLD_HOUR] = cur_hour;
    assign alm_arr[FLD_SEC]  = alm_sec;
    assign alm_arr[FLD_MIN]  = alm_min;
    assign alm_arr[FLD_HOUR] = alm_hour;

    // One comparator per field; the hour field gets PM handling.
    generate
        for (genvar g = 0; g < NFLD; g++) begin : g_fld
            tod_field_match #(
                .BYTE_W  (BYTE_W),
                .IS_HOUR (g == TOD_HOUR_IDX)
            ) i_match (
                .cur_raw  (cur_arr[g]),
                .alm_raw  (alm_arr[g]),
                .bin_mode (bin_mode),
                .h24_mode (h24_mode),
                .hit      (fld_hit[g])
            );
        end
    endgenerate

    // An update counts only when the dividers are running.
    assign accept = upd_stb && !div_hold;

    tod_flag_stage i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .all_match (&fld_hit),
        .upd_done  (upd_done),
        .alarm_hit (alarm_hit)
    );
endmodule

// File: rtl/tod_alarm_cmp_chk.sv
// Module: tod_alarm_cmp_chk
// Port-level temporal checks for tod_alarm_cmp, attached with bind.
module tod_alarm_cmp_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_stb,
    input logic              div_hold,
    input logic [BYTE_W-1:0] alm_sec,
    input logic [BYTE_W-1:0] alm_min,
    input logic [BYTE_W-1:0] alm_hour,
    input logic              upd_done,
    input logic              alarm_hit
);
    logic all_wild;
    assign all_wild = (alm_sec[BYTE_W-1:BYTE_W-2] == 2'b11) &&
                      (alm_min[BYTE_W-1:BYTE_W-2] == 2'b11) &&
                      (alm_hour[BYTE_W-1:BYTE_W-2] == 2'b11);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!upd_done && !alarm_hit));

    assert_upd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && !div_hold) |=> upd_done);

    assert_no_stb_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |=> !upd_done);

    assert_hold_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_hold |=> (!upd_done && !alarm_hit));

    assert_all_wild_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && !div_hold && all_wild) |=> alarm_hit);

    assert_alarm_with_upd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> upd_done);
endmodule

bind tod_alarm_cmp tod_alarm_cmp_chk #(.BYTE_W(BYTE_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_stb   (upd_stb),
    .div_hold  (div_hold),
    .alm_sec   (alm_sec),
    .alm_min   (alm_min),
    .alm_hour  (alm_hour),
    .upd_done  (upd_done),
    .alarm_hit (alarm_hit)
);

// File: tb/test_tod_alarm_cmp.sv
// Directed bench for tod_alarm_cmp: one task per scenario.
module test_tod_alarm_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_stb = 1'b0;
    logic       div_hold = 1'b0;
    logic       bin_mode = 1'b0;
    logic       h24_mode = 1'b1;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic [7:0] alm_sec = '0, alm_min = '0, alm_hour = '0;
    logic       upd_done, alarm_hit;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tod_alarm_cmp i_tod_alarm_cmp (
        .clk (clk), .rst_n (rst_n), .upd_stb (upd_stb), .div_hold (div_hold),
        .bin_mode (bin_mode), .h24_mode (h24_mode),
        .cur_sec (cur_sec), .cur_min (cur_min), .cur_hour (cur_hour),
        .alm_sec (alm_sec), .alm_min (alm_min), .alm_hour (alm_hour),
        .upd_done (upd_done), .alarm_hit (alarm_hit)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Apply one update strobe with given bytes; check the flag cycle and
    // the cycle after it (pulses must have dropped).
    task automatic run_update(input string tag,
                              input logic [7:0] cs, cm, ch, as, am, ah,
                              input logic exp_done, exp_alm);
        @(negedge clk);
        cur_sec = cs; cur_min = cm; cur_hour = ch;
        alm_sec = as; alm_min = am; alm_hour = ah;
        upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        check({tag, " upd_done"}, upd_done, exp_done);
        check({tag, " alarm_hit"}, alarm_hit, exp_alm);
        @(negedge clk);
        check({tag, " R2 upd_done drop"}, upd_done, 1'b0);
        check({tag, " alarm_hit drop"}, alarm_hit, 1'b0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        upd_stb = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset upd_done", upd_done, 1'b0);
        check("R1 reset alarm_hit", alarm_hit, 1'b0);
        upd_stb = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle upd_done", upd_done, 1'b0);
    endtask

    task automatic t_bcd_match;
        bin_mode = 1'b0; h24_mode = 1'b1;
        run_update("R4 bcd match", 8'h30, 8'h45, 8'h23, 8'h30, 8'h45, 8'h23, 1'b1, 1'b1);
    endtask

    task automatic t_mismatch;
        run_update("R5 sec differs", 8'h30, 8'h45, 8'h23, 8'h31, 8'h45, 8'h23, 1'b1, 1'b0);
        run_update("R5 min differs", 8'h30, 8'h45, 8'h23, 8'h30, 8'h46, 8'h23, 1'b1, 1'b0);
        run_update("R5 hour differs", 8'h30, 8'h45, 8'h23, 8'h30, 8'h45, 8'h22, 1'b1, 1'b0);
    endtask

    task automatic t_hold;
        div_hold = 1'b1;
        run_update("R3 hold", 8'h10, 8'h10, 8'h10, 8'hC0, 8'hC0, 8'hC0, 1'b0, 1'b0);
        div_hold = 1'b0;
    endtask

    task automatic t_wildcard;
        run_update("R6 wild sec", 8'h17, 8'h05, 8'h08, 8'hC0, 8'h05, 8'h08, 1'b1, 1'b1);
        run_update("R6 wild hour", 8'h17, 8'h05, 8'h08, 8'h17, 8'h05, 8'hFF, 1'b1, 1'b1);
        run_update("R6 wild other differs", 8'h17, 8'h05, 8'h08, 8'hC0, 8'h06, 8'h08, 1'b1, 1'b0);
    endtask

    task automatic t_all_wild;
        run_update("R7 all wild a", 8'h00, 8'h00, 8'h00, 8'hC5, 8'hD0, 8'hFF, 1'b1, 1'b1);
        run_update("R7 all wild b", 8'h59, 8'h33, 8'h19, 8'hC5, 8'hD0, 8'hFF, 1'b1, 1'b1);
    endtask

    task automatic t_binary;
        bin_mode = 1'b1;
        run_update("R8 bin match", 8'h1E, 8'h3B, 8'h17, 8'h1E, 8'h3B, 8'h17, 1'b1, 1'b1);
        run_update("R8 bin vs bcd 0x30", 8'h1E, 8'h3B, 8'h17, 8'h30, 8'h3B, 8'h17, 1'b1, 1'b0);
        bin_mode = 1'b0;
        run_update("R8 bcd 0x1E is 24", 8'h24, 8'h00, 8'h00, 8'h1E, 8'h00, 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_twelve_hour;
        h24_mode = 1'b0;
        run_update("R9 12 AM is 0", 8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
        run_update("R9 1 PM match", 8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h81, 1'b1, 1'b1);
        run_update("R9 1 PM vs 1 AM", 8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0);
        bin_mode = 1'b1;
        run_update("R9 bin 12 PM is 12", 8'h00, 8'h00, 8'h8C, 8'h00, 8'h00, 8'h80, 1'b1, 1'b1);
        bin_mode = 1'b0;
        h24_mode = 1'b1;
    endtask

    task automatic t_pm_masked_24h;
        run_update("R11 pm bit dropped", 8'h00, 8'h00, 8'h15, 8'h00, 8'h00, 8'h95, 1'b1, 1'b1);
    endtask

    task automatic t_alarm_needs_update;
        // R10: matching bytes without a strobe must not raise alarm_hit.
        @(negedge clk);
        cur_sec = 8'h01; alm_sec = 8'h01;
        cur_min = 8'h02; alm_min = 8'h02;
        cur_hour = 8'h03; alm_hour = 8'h03;
        @(negedge clk);
        check("R10 no strobe alarm_hit", alarm_hit, 1'b0);
        check("R10 no strobe upd_done", upd_done, 1'b0);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        t_reset();
        t_bcd_match();
        t_mismatch();
        t_hold();
        t_wildcard();
        t_all_wild();
        t_binary();
        t_twelve_hour();
        t_pm_masked_24h();
        t_alarm_needs_update();
        finished = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end
endmodule